// File: doc/BRIEF.md
# Sleep Mode and Wake-Up Sequencer

This block decides when a small 8-bit processor core goes to sleep and how it wakes. The core sends a one-cycle sleep strobe. The block acts on it only when the sleep-enable control bit is set. It then records the requested low-power mode, switches off the clock domains that mode does not need, and holds the core halted. A wake source that is valid for the recorded mode ends the sleep.

Waking runs in a fixed order. Deep modes first wait for the oscillator, using a start-up count supplied by the caller. Every mode then adds a fixed stall of four cycles. When the stall ends, the core is released and a one-cycle resume pulse is raised, so the core can service the interrupt and continue after its sleep instruction. A reset ends any phase at once and returns every output to its run value without a resume pulse, so the core restarts from its reset vector.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: When the block is running, a `sleep_strobe` sampled with `sleep_en`=1 puts it to sleep (`core_halt`=1 from the next cycle). A strobe with `sleep_en`=0 is ignored and `core_halt` stays 0.
- R2: The `mode_sel` codes are 000 Idle, 001 ADC-quiet, 010 Power-down, 011 Power-save and 110 Standby. Every other code acts as Idle. Code 110 with `ext_xtal`=0 acts as Power-down.
- R3: The enables {cpu, io, adc, async, osc} are 11111 while running. While asleep they are 01111 in Idle, 00111 in ADC-quiet, 00000 in Power-down, 000a0 in Power-save (a = `async_mode`) and 00001 in Standby.
- R4: `wake_src` bits are: 0 external level, 1 external edge, 2 pin change, 3 asynchronous timer, 4 display controller, 5 ADC done, 6 other I/O. Idle accepts every bit. ADC-quiet accepts bits 0, 2 and 5. Power-down and Standby accept bits 0 and 2. A bit outside the accepted set leaves the block asleep.
- R5: The external edge bit (1) wakes the block only in Idle. In every other mode it has no effect.
- R6: In ADC-quiet and Power-save, bits 3 and 4 wake the block only when `async_mode`=1.
- R7: Count core-halt cycles from the clock edge that detects the wake. The core stays halted for `startup_cycles` plus 4 cycles in Power-down, Power-save and Standby, and for 4 cycles in Idle and ADC-quiet. `resume` is high for exactly the first released cycle.
- R8: During the start-up wait, `osc_en`=1 and the other enables keep their sleep values. During the four-cycle stall the enables are 01111.
- R9: A reset at any point drives the enables to 11111 and `core_halt` to 0, and `resume` is not raised.
- R10: A sleep strobe that arrives during the wake sequence is ignored. The wake timing is unchanged and the block stays running afterwards.
- R11: The mode is captured when sleep starts. A change of `mode_sel` during sleep changes neither the wake sources nor the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_en | input | 1 | Allows a sleep strobe to take effect |
| mode_sel | input | 3 | Requested sleep mode code |
| sleep_strobe | input | 1 | One-cycle sleep request from the core |
| wake_src | input | 7 | Enabled interrupt requests, by bit position |
| async_mode | input | 1 | Asynchronous timer and display controller run from their own clock |
| ext_xtal | input | 1 | External crystal or resonator is the clock source |
| startup_cycles | input | CNT_W | Oscillator start-up wait in cycles |
| clk_en_cpu | output | 1 | CPU clock enable |
| clk_en_io | output | 1 | I/O clock enable |
| clk_en_adc | output | 1 | ADC clock enable |
| clk_en_async | output | 1 | Asynchronous timer clock enable |
| osc_en | output | 1 | Main oscillator run |
| core_halt | output | 1 | Core is stalled |
| resume | output | 1 | One-cycle pulse when the core is released after a wake |

## Verification
The bench builds the block with CNT_W=4. With that width the largest start-up count, 15, takes only a few cycles, so the counter can be tested at zero, at a middle value and at its maximum. The middle value of 3 keeps every run in the mode table short. The largest count is used to check that the start-up wait is added to the four-cycle stall.

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl #(
  parameter int CNT_W    = 8,
  parameter int HALT_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_en,
  input  logic [2:0]       mode_sel,
  input  logic             sleep_strobe,
  input  logic [6:0]       wake_src,
  input  logic             async_mode,
  input  logic             ext_xtal,
  input  logic [CNT_W-1:0] startup_cycles,
  output logic             clk_en_cpu,
  output logic             clk_en_io,
  output logic             clk_en_adc,
  output logic             clk_en_async,
  output logic             osc_en,
  output logic             core_halt,
  output logic             resume
);

  localparam int HC_W = $clog2(HALT_CYC + 1);
  localparam int CW   = (CNT_W > HC_W) ? CNT_W : HC_W;

  typedef enum logic [1:0] {S_RUN, S_SLEEP, S_START, S_HALT} st_t;
  typedef enum logic [2:0] {M_IDLE, M_ADCQ, M_PDOWN, M_PSAVE, M_STBY} md_t;

  st_t           st;
  md_t           mode_q, mode_eff;
  logic [CW-1:0] cnt;
  logic [6:0]    wake_mask;
  logic          deep, wake;
  logic [4:0]    en;

  always_comb begin
    case (mode_sel)
      3'b001:  mode_eff = M_ADCQ;
      3'b010:  mode_eff = M_PDOWN;
      3'b011:  mode_eff = M_PSAVE;
      3'b110:  mode_eff = ext_xtal ? M_STBY : M_PDOWN;
      default: mode_eff = M_IDLE;
    endcase
  end

  assign deep = (mode_q == M_PDOWN) || (mode_q == M_PSAVE) || (mode_q == M_STBY);

  always_comb begin
    case (mode_q)
      M_IDLE:  wake_mask = 7'b111_1111;
      M_ADCQ:  wake_mask = {1'b0, 1'b1, async_mode, async_mode, 1'b1, 1'b0, 1'b1};
      M_PSAVE: wake_mask = {1'b0, 1'b0, async_mode, async_mode, 1'b1, 1'b0, 1'b1};
      default: wake_mask = 7'b000_0101;
    endcase
  end

  assign wake = |(wake_src & wake_mask);

  always_comb begin
    en = 5'b11111;
    case (st)
      S_HALT: en = 5'b01111;
      S_SLEEP, S_START: begin
        case (mode_q)
          M_IDLE:  en = 5'b01111;
          M_ADCQ:  en = 5'b00111;
          M_PSAVE: en = {3'b000, async_mode, 1'b0};
          M_STBY:  en = 5'b00001;
          default: en = 5'b00000;
        endcase
        if (st == S_START) en[0] = 1'b1;
      end
      default: en = 5'b11111;
    endcase
  end

  assign {clk_en_cpu, clk_en_io, clk_en_adc, clk_en_async, osc_en} = en;
  assign core_halt = (st != S_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_RUN;
      mode_q <= M_IDLE;
      cnt    <= '0;
      resume <= 1'b0;
    end else begin
      resume <= 1'b0;
      case (st)
        S_RUN: if (sleep_strobe && sleep_en) begin
          st     <= S_SLEEP;
          mode_q <= mode_eff;
        end
        S_SLEEP: if (wake) begin
          if (deep && startup_cycles != '0) begin
            st  <= S_START;
            cnt <= CW'(startup_cycles);
          end else begin
            st  <= S_HALT;
            cnt <= CW'(HALT_CYC - 1);
          end
        end
        S_START: begin
          if (cnt <= CW'(1)) begin
            st  <= S_HALT;
            cnt <= CW'(HALT_CYC - 1);
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        default: begin
          if (cnt == '0) begin
            st     <= S_RUN;
            resume <= 1'b1;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
      endcase
    end
  end

  AST_STROBE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && sleep_strobe && !sleep_en) |=> !core_halt); // R1
  AST_STROBE_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && sleep_strobe && sleep_en) |=> core_halt); // R1
  AST_EDGE_DEEP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SLEEP && mode_q != M_IDLE && wake_src == 7'b000_0010) |=> (st == S_SLEEP)); // R5
  AST_SHALLOW_SKIPS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SLEEP && !deep && wake) |=> (st == S_HALT)); // R7
  AST_RELEASE_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_halt) |-> (resume && $past(st == S_HALT, 1) && $past(st == S_HALT, 4))); // R7
  AST_RESUME_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume); // R7
  AST_START_OSC_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START) |-> (osc_en && !clk_en_cpu)); // R8

endmodule

// File: tb/sleep_wake_ctrl_bench.sv
module sleep_wake_ctrl_bench;
  localparam int CNT_W = 4;
  localparam int NV    = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep_en = 1'b0, sleep_strobe = 1'b0, async_mode = 1'b0, ext_xtal = 1'b1;
  logic [2:0] mode_sel = 3'b000;
  logic [6:0] wake_src = '0;
  logic [CNT_W-1:0] startup_cycles = 4'd3;
  logic clk_en_cpu, clk_en_io, clk_en_adc, clk_en_async, osc_en, core_halt, resume;
  logic [4:0] ens;
  int n_chk = 0, n_bad = 0;

  assign ens = {clk_en_cpu, clk_en_io, clk_en_adc, clk_en_async, osc_en};

  sleep_wake_ctrl #(.CNT_W(CNT_W), .HALT_CYC(4)) u_sleep_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .mode_sel(mode_sel),
    .sleep_strobe(sleep_strobe), .wake_src(wake_src), .async_mode(async_mode),
    .ext_xtal(ext_xtal), .startup_cycles(startup_cycles),
    .clk_en_cpu(clk_en_cpu), .clk_en_io(clk_en_io), .clk_en_adc(clk_en_adc),
    .clk_en_async(clk_en_async), .osc_en(osc_en), .core_halt(core_halt), .resume(resume));

  always #10 clk = ~clk;

  // {mode[2:0], xtal, async, src[6:0], exp_en[4:0], exp_wake}
  localparam logic [17:0] VEC [NV] = '{
    {3'b000, 1'b1, 1'b0, 7'b0000010, 5'b01111, 1'b1},
    {3'b000, 1'b1, 1'b0, 7'b1000000, 5'b01111, 1'b1},
    {3'b001, 1'b1, 1'b0, 7'b0100000, 5'b00111, 1'b1},
    {3'b001, 1'b1, 1'b0, 7'b1000000, 5'b00111, 1'b0},
    {3'b001, 1'b1, 1'b0, 7'b0000010, 5'b00111, 1'b0},
    {3'b001, 1'b1, 1'b1, 7'b0001000, 5'b00111, 1'b1},
    {3'b010, 1'b1, 1'b0, 7'b0000001, 5'b00000, 1'b1},
    {3'b010, 1'b1, 1'b0, 7'b0000010, 5'b00000, 1'b0},
    {3'b010, 1'b1, 1'b0, 7'b0100000, 5'b00000, 1'b0},
    {3'b011, 1'b1, 1'b0, 7'b0001000, 5'b00000, 1'b0},
    {3'b011, 1'b1, 1'b1, 7'b0010000, 5'b00010, 1'b1},
    {3'b011, 1'b1, 1'b1, 7'b0000100, 5'b00010, 1'b1},
    {3'b110, 1'b1, 1'b0, 7'b0000001, 5'b00001, 1'b1},
    {3'b110, 1'b0, 1'b0, 7'b0000001, 5'b00000, 1'b1},
    {3'b111, 1'b1, 1'b0, 7'b1000000, 5'b01111, 1'b1},
    {3'b110, 1'b1, 1'b0, 7'b0000010, 5'b00001, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit is_deep(input logic [2:0] m, input logic x);
    return (m == 3'b010) || (m == 3'b011) || (m == 3'b110);
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic enter_sleep(input logic [2:0] m, input logic x, input logic a);
    @(negedge clk);
    mode_sel = m; ext_xtal = x; async_mode = a; sleep_en = 1'b1; sleep_strobe = 1'b1;
    @(negedge clk);
    sleep_strobe = 1'b0;
  endtask

  // returns negedges until core_halt drops (0 if still halted after limit)
  task automatic wake_run(input logic [6:0] s, input int limit, output int n, output bit res_ok);
    n = 0; res_ok = 1'b0;
    @(negedge clk); wake_src = s;
    while (n < limit) begin
      @(negedge clk); n++;
      if (!core_halt) begin res_ok = resume; break; end
    end
    if (core_halt) n = 0;
    wake_src = '0;
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    bit rok;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ens == 5'b11111 && !core_halt && !resume, "R9 reset state", ens, 31);

    // R1: strobe without enable ignored
    @(negedge clk); sleep_en = 1'b0; sleep_strobe = 1'b1; mode_sel = 3'b010;
    @(negedge clk); sleep_strobe = 1'b0;
    chk(!core_halt, "R1 strobe ignored when disabled", core_halt, 0);

    // table walk, startup count 3
    for (int i = 0; i < NV; i++) begin
      logic [2:0] m;
      logic x, a, w, dp;
      logic [6:0] s;
      logic [4:0] e;
      int lat;
      {m, x, a, s, e, w} = VEC[i];
      dp = is_deep(m, x);
      lat = dp ? 3 + 5 : 5;
      enter_sleep(m, x, a);
      chk(core_halt == 1'b1, "R1 sleep entered", core_halt, 1);
      chk(ens == e, "R2 R3 sleep enables", ens, e);
      wake_run(s, 30, n, rok);
      if (w) begin
        chk(n == lat, "R4 R7 wake latency", n, lat);
        chk(rok, "R7 resume pulse", rok, 1);
        @(negedge clk);
        chk(!resume && !core_halt, "R7 resume single cycle", resume, 0);
      end else begin
        chk(n == 0 && ens == e, "R4 R5 R6 masked source keeps sleep", ens, e);
        do_reset();
        chk(!core_halt && ens == 5'b11111 && !resume, "R9 reset during sleep", ens, 31);
      end
    end

    // R8: start-up and stall enables in Power-down
    enter_sleep(3'b010, 1'b1, 1'b0);
    @(negedge clk); wake_src = 7'b0000100;
    @(negedge clk); wake_src = '0;
    chk(ens == 5'b00001, "R8 start-up enables", ens, 1);
    repeat (3) @(negedge clk);
    chk(ens == 5'b01111 && core_halt, "R8 stall enables", ens, 15);
    repeat (4) @(negedge clk);
    chk(!core_halt && resume, "R7 release after stall", core_halt, 0);

    // R7: start-up count zero and maximum
    startup_cycles = 4'd0;
    enter_sleep(3'b011, 1'b1, 1'b0);
    wake_run(7'b0000001, 40, n, rok);
    chk(n == 5, "R7 zero start-up", n, 5);
    startup_cycles = 4'd15;
    enter_sleep(3'b110, 1'b1, 1'b0);
    wake_run(7'b0000001, 40, n, rok);
    chk(n == 20, "R7 max start-up", n, 20);
    startup_cycles = 4'd3;

    // R10: strobe during wake ignored
    enter_sleep(3'b000, 1'b1, 1'b0);
    @(negedge clk); wake_src = 7'b0000001;
    @(negedge clk); wake_src = '0; sleep_strobe = 1'b1; sleep_en = 1'b1;
    @(negedge clk); sleep_strobe = 1'b0;
    repeat (3) @(negedge clk);
    chk(!core_halt && resume, "R10 wake timing kept", core_halt, 0);
    repeat (3) @(negedge clk);
    chk(!core_halt, "R10 stays running", core_halt, 0);

    // R11: mode change while asleep
    enter_sleep(3'b010, 1'b1, 1'b0);
    mode_sel = 3'b000;
    wake_run(7'b1000000, 20, n, rok);
    chk(n == 0 && ens == 5'b00000, "R11 mode latched", ens, 0);
    do_reset();
    chk(!core_halt && !resume, "R9 reset exits sleep", core_halt, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule